// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block drives the command and address phase of a raw page read on an 8-bit asynchronous NAND device. A one-cycle start request launches the sequence. The block then emits a read opcode, two column-address bytes, a selectable number of row-address bytes and a confirm opcode. Each byte goes out on its own write-enable strobe, with the command-latch or address-latch line marking what kind of byte it is.

After the confirm byte, the block watches the ready/busy line. The device must first go busy and then come back ready. When that happens the block raises a one-cycle completion pulse, which stands in for the data-out phase. If the device never comes back, a timeout turns the wait into a one-cycle error pulse.

A 2-bit configuration code sets the length of the address phase:
- Code 00 sends three row bytes, so five address cycles in total.
- Code 01 sends two row bytes, so four address cycles in total.
- Codes 10 and 11 are reserved. A start request that carries either one is refused.

Because an all-zero code selects the longer form, an unprogrammed configuration works with the larger devices.

Top module: `nand_page_reader`

## Requirements
- R1: The first latch cycle of every accepted read has command-latch high, address-latch low and the byte 0x00.
- R2: The next two latch cycles are address cycles (address-latch high) carrying the column address, bits 7:0 first and then bits 15:8.
- R3: The column bytes are followed by the row bytes, lowest row byte (bits 7:0) first. Code 2'b00 gives three row bytes and code 2'b01 gives two.
- R4: The last latch cycle is a command cycle carrying 0x30, so a read has 7 latch cycles for code 00 and 6 for code 01.
- R5: A start request with code 2'b10 or 2'b11 produces no write-enable strobe and no latch cycle, and raises the error output for exactly one cycle.
- R6: In each latch cycle, write-enable is low for WE_CLKS clocks and then high for WE_CLKS clocks. The byte, command-latch and address-latch values do not change on the clock where write-enable rises.
- R7: Command-latch and address-latch are never high together. When neither is high, write-enable is high and the I/O byte is 0x00.
- R8: After the confirm byte, the completion output pulses for exactly one cycle once ready/busy (high = ready) has been seen low and then high.
- R9: If ready/busy does not finish its low-then-high cycle within TIMEOUT_CLKS clocks of a wait state, the error output pulses for one cycle and no completion pulse is given.
- R10: Row-address bits above the selected row bytes are never sent: with code 01, bits 23:16 have no effect on the bus.
- R11: A start request made while a read is in progress is ignored. The sequence continues with the addresses captured at the accepted start.
- R12: Out of reset, write-enable is high, both latch lines are low, the I/O byte is 0x00 and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to begin a page read |
| colAddr | input | 16 | Column address, captured at an accepted start |
| rowAddr | input | 24 | Row (page) address, captured at an accepted start |
| rowCfg | input | 2 | Row-byte count code: 00 = three, 01 = two, 1x = reserved |
| nandRdyBsy | input | 1 | Device ready/busy, high = ready |
| nandCle | output | 1 | Command-latch enable |
| nandAle | output | 1 | Address-latch enable |
| nandWeN | output | 1 | Active-low write-enable strobe |
| nandIo | output | 8 | Byte driven to the device |
| doneFlag | output | 1 | One-cycle pulse when the page is ready |
| errFlag | output | 1 | One-cycle pulse on reserved code or timeout |

## Verification
Random column and row addresses are driven with both valid codes, and each latched byte is compared with the expected byte and latch type. This separates code 00 from code 01 by byte count and row-byte order, and it shows that the upper row bits are dropped in the two-row form. Directed cases cover:
- Both reserved codes, to tell a refused start from a silent one.
- A ready line that never toggles, to tell a timeout from a completion.
- A second start request during a read with different addresses, to show that the first captured addresses are kept.

The strobe low and high widths are measured on every byte, so a change in strobe pacing is caught apart from a change in the byte values.

// File: rtl/nandrd_pkg.sv
package nandrd_pkg;
  localparam int COL_BYTES = 2;
  localparam int ROW_BYTES_MAX = 3;
  localparam int COL_W = 8 * COL_BYTES;
  localparam int ROW_W = 8 * ROW_BYTES_MAX;
  localparam int IDX_W = 3;
  localparam logic [7:0] OP_READ = 8'h00;
  localparam logic [7:0] OP_CONFIRM = 8'h30;

  // control-to-datapath strobes
  typedef struct packed {
    logic captureAddr;
    logic busActive;
    logic weLow;
    logic isConfirm;
    logic [IDX_W-1:0] byteIdx;
  } busStrobe_t;
endpackage

// File: rtl/nandrd_dpath.sv
module nandrd_dpath
  import nandrd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [COL_W-1:0] colAddr,
  input  logic [ROW_W-1:0] rowAddr,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic [7:0]       nandIo
);
  logic [COL_W-1:0] colQ;
  logic [ROW_W-1:0] rowQ;
  logic [7:0]       selByte;
  logic             isCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ <= '0;
      rowQ <= '0;
    end else if (strobe.captureAddr) begin
      colQ <= colAddr;
      rowQ <= rowAddr;
    end
  end

  always_comb begin
    selByte = OP_READ;
    for (int k = 0; k < COL_BYTES; k++)
      if (strobe.byteIdx == IDX_W'(1 + k)) selByte = colQ[8*k +: 8];
    for (int k = 0; k < ROW_BYTES_MAX; k++)
      if (strobe.byteIdx == IDX_W'(1 + COL_BYTES + k)) selByte = rowQ[8*k +: 8];
    if (strobe.isConfirm) selByte = OP_CONFIRM;
  end

  assign isCmd = strobe.isConfirm || (strobe.byteIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nandCle <= 1'b0;
      nandAle <= 1'b0;
      nandWeN <= 1'b1;
      nandIo  <= 8'h00;
    end else begin
      nandCle <= strobe.busActive && isCmd;
      nandAle <= strobe.busActive && !isCmd;
      nandWeN <= !strobe.weLow;
      nandIo  <= strobe.busActive ? selByte : 8'h00;
    end
  end

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R7
  AST_BYTE_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> ($stable(nandIo) && $stable(nandCle) && $stable(nandAle))); // R6
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!nandCle && !nandAle) |-> (nandWeN && nandIo == 8'h00)); // R7
endmodule

// File: rtl/nandrd_ctrl.sv
module nandrd_ctrl
  import nandrd_pkg::*;
#(
  parameter int WE_CLKS = 2,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] rowCfg,
  input  logic       nandRdyBsy,
  output busStrobe_t strobe,
  output logic       doneFlag,
  output logic       errFlag
);
  localparam int PH_W = $clog2(WE_CLKS + 1);
  localparam int TO_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WE_CLKS - 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CLKS - 1);
  localparam logic [IDX_W-1:0] LAST_LONG = IDX_W'(1 + COL_BYTES + ROW_BYTES_MAX);

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_WAIT_LOW, S_WAIT_HIGH} state_t;

  state_t           state;
  logic [IDX_W-1:0] byteIdx, lastIdx;
  logic [PH_W-1:0]  phaseCnt;
  logic [TO_W-1:0]  toCnt;
  logic             phaseHigh;
  logic             startOk, startBad;

  assign startOk  = (state == S_IDLE) && startReq && !rowCfg[1];
  assign startBad = (state == S_IDLE) && startReq && rowCfg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      byteIdx   <= '0;
      lastIdx   <= LAST_LONG;
      phaseCnt  <= '0;
      phaseHigh <= 1'b0;
      toCnt     <= '0;
      doneFlag  <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (startOk) begin
            state     <= S_LATCH;
            byteIdx   <= '0;
            phaseCnt  <= '0;
            phaseHigh <= 1'b0;
            lastIdx   <= rowCfg[0] ? LAST_LONG - IDX_W'(1) : LAST_LONG;
          end else if (startBad) begin
            errFlag <= 1'b1;
          end
        end
        S_LATCH: begin
          if (phaseCnt == PH_LAST) begin
            phaseCnt <= '0;
            if (!phaseHigh) begin
              phaseHigh <= 1'b1;
            end else begin
              phaseHigh <= 1'b0;
              if (byteIdx == lastIdx) begin
                state <= S_WAIT_LOW;
                toCnt <= '0;
              end else begin
                byteIdx <= byteIdx + IDX_W'(1);
              end
            end
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        S_WAIT_LOW: begin
          if (!nandRdyBsy) begin
            state <= S_WAIT_HIGH;
            toCnt <= '0;
          end else if (toCnt == TO_LAST) begin
            state   <= S_IDLE;
            errFlag <= 1'b1;
          end else begin
            toCnt <= toCnt + TO_W'(1);
          end
        end
        S_WAIT_HIGH: begin
          if (nandRdyBsy) begin
            state    <= S_IDLE;
            doneFlag <= 1'b1;
          end else if (toCnt == TO_LAST) begin
            state   <= S_IDLE;
            errFlag <= 1'b1;
          end else begin
            toCnt <= toCnt + TO_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.captureAddr = startOk;
    strobe.busActive   = (state == S_LATCH);
    strobe.weLow       = (state == S_LATCH) && !phaseHigh;
    strobe.isConfirm   = (byteIdx == lastIdx);
    strobe.byteIdx     = byteIdx;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(doneFlag && errFlag)); // R9
  AST_RESERVED_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startReq && rowCfg[1]) |=> (state == S_IDLE && errFlag)); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LATCH && byteIdx != '0) |=> (byteIdx != '0 || state != S_LATCH)); // R11
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nandrd_pkg::*;
#(
  parameter int WE_CLKS = 2,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [15:0] colAddr,
  input  logic [23:0] rowAddr,
  input  logic [1:0]  rowCfg,
  input  logic        nandRdyBsy,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic [7:0]  nandIo,
  output logic        doneFlag,
  output logic        errFlag
);
  busStrobe_t strobe;

  nandrd_ctrl #(.WE_CLKS(WE_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rowCfg(rowCfg),
    .nandRdyBsy(nandRdyBsy), .strobe(strobe), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  nandrd_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colAddr(colAddr), .rowAddr(rowAddr),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandIo(nandIo)
  );
endmodule

// File: tb/nand_page_reader_bench.sv
module nand_page_reader_bench;
  localparam int WE = 2;
  localparam int TO = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [15:0] colAddr = '0;
  logic [23:0] rowAddr = '0;
  logic [1:0] rowCfg = '0;
  logic nandRdyBsy = 1'b1;
  logic nandCle, nandAle, nandWeN, doneFlag, errFlag;
  logic [7:0] nandIo;

  int checks = 0;
  int errors = 0;

  nand_page_reader #(.WE_CLKS(WE), .TIMEOUT_CLKS(TO)) u_nand_page_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .colAddr(colAddr), .rowAddr(rowAddr),
    .rowCfg(rowCfg), .nandRdyBsy(nandRdyBsy), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandIo(nandIo), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  // monitor: captures each byte at the write-enable rising sample
  logic [7:0] capByte [0:1023];
  logic       capCle  [0:1023];
  logic       capAle  [0:1023];
  int capCount = 0, doneCount = 0, errCount = 0, lowSamples = 0, widthBad = 0;
  int lowRun = 0, highRun = 0;
  logic prevWeN = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (doneFlag) doneCount++;
      if (errFlag) errCount++;
      if (!nandWeN) begin
        lowSamples++;
        lowRun++;
        if (prevWeN) begin
          if (!(nandCle && nandIo == 8'h00) && highRun != WE) widthBad++;
        end
      end else begin
        highRun++;
        if (!prevWeN) begin
          if (lowRun != WE) widthBad++;
          if (capCount < 1024) begin
            capByte[capCount] = nandIo;
            capCle[capCount] = nandCle;
            capAle[capCount] = nandAle;
          end
          capCount++;
          lowRun = 0;
          highRun = 1;
        end
      end
      prevWeN = nandWeN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int rowCount(input logic [1:0] cfg);
    return (cfg == 2'b00) ? 3 : 2;
  endfunction

  function automatic logic [7:0] expByte(input int i, input logic [15:0] c,
                                         input logic [23:0] r, input logic [1:0] cfg);
    if (i == 0) return 8'h00;
    if (i == 1) return c[7:0];
    if (i == 2) return c[15:8];
    if (i < 3 + rowCount(cfg)) return r[8*(i-3) +: 8];
    return 8'h30;
  endfunction

  function automatic bit expCmd(input int i, input logic [1:0] cfg);
    return (i == 0) || (i == 3 + rowCount(cfg));
  endfunction

  task automatic runRead(input logic [15:0] c, input logic [23:0] r, input logic [1:0] cfg,
                         input bit doubleStart, input bit neverReady);
    int base, dBase, eBase, wBase, nExp, waitCyc;
    base = capCount;
    wBase = widthBad;
    nExp = 4 + rowCount(cfg);
    @(negedge clk);
    colAddr = c; rowAddr = r; rowCfg = cfg; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (doubleStart) begin
      repeat (3) @(negedge clk);
      colAddr = ~c; rowAddr = ~r; rowCfg = 2'b00; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    waitCyc = 0;
    while (capCount - base < nExp && waitCyc < 200) begin
      @(negedge clk);
      waitCyc++;
    end
    check(capCount - base == nExp, "R4 latch cycle count", capCount - base, nExp);
    for (int i = 0; i < nExp; i++) begin
      string tag;
      tag = (i == 0) ? "R1 opcode" : (i < 3) ? "R2 column byte" :
            (i < 3 + rowCount(cfg)) ? (doubleStart ? "R11 byte after ignored start" : "R3 row byte")
            : "R4 confirm";
      check(capByte[base+i] == expByte(i, c, r, cfg), tag, capByte[base+i], expByte(i, c, r, cfg));
      check(capCle[base+i] == expCmd(i, cfg) && capAle[base+i] == !expCmd(i, cfg),
            "R7 latch line type", {capCle[base+i], capAle[base+i]}, {expCmd(i, cfg), !expCmd(i, cfg)});
    end
    repeat (2*WE + 3) @(negedge clk);
    check(widthBad == wBase, "R6 strobe widths", widthBad - wBase, 0);
    check(capCount - base == nExp, "R11 no extra latch cycles", capCount - base, nExp);
    dBase = doneCount;
    eBase = errCount;
    if (neverReady) begin
      repeat (TO + 10) @(negedge clk);
      check(errCount - eBase == 1, "R9 timeout error pulse", errCount - eBase, 1);
      check(doneCount == dBase, "R9 no done on timeout", doneCount - dBase, 0);
    end else begin
      check(doneCount == dBase, "R8 no done before busy", doneCount - dBase, 0);
      nandRdyBsy = 1'b0;
      repeat (5) @(negedge clk);
      check(doneCount == dBase, "R8 no done while busy", doneCount - dBase, 0);
      nandRdyBsy = 1'b1;
      repeat (6) @(negedge clk);
      check(doneCount - dBase == 1, "R8 single done pulse", doneCount - dBase, 1);
      check(errCount == eBase, "R8 no error on good read", errCount - eBase, 0);
    end
  endtask

  task automatic reservedStart(input logic [1:0] cfg);
    int base, eBase, lBase;
    base = capCount; eBase = errCount; lBase = lowSamples;
    @(negedge clk);
    rowCfg = cfg; colAddr = 16'hBEEF; rowAddr = 24'h123456; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (20) @(negedge clk);
    check(errCount - eBase == 1, "R5 reserved code error pulse", errCount - eBase, 1);
    check(lowSamples == lBase && capCount == base, "R5 no bus activity", lowSamples - lBase, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(nandWeN == 1'b1 && !nandCle && !nandAle && nandIo == 8'h00 && !doneFlag && !errFlag,
          "R12 reset state", {nandWeN, nandCle, nandAle, doneFlag, errFlag}, 5'b10000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(nandWeN == 1'b1 && nandIo == 8'h00, "R7 idle bus", nandIo, 0);
    // directed corners
    runRead(16'h1234, 24'hAB5678, 2'b01, 1'b0, 1'b0); // R10 high row byte dropped
    runRead(16'h0000, 24'hFFFFFF, 2'b00, 1'b0, 1'b0);
    runRead(16'hFFFF, 24'h000000, 2'b00, 1'b1, 1'b0); // R11
    reservedStart(2'b10);
    reservedStart(2'b11);
    runRead(16'h00A5, 24'h5A5A5A, 2'b00, 1'b0, 1'b1); // R9
    // random reads
    for (int n = 0; n < 24; n++) begin
      logic [1:0] cfg;
      cfg = 2'($urandom_range(0, 1));
      runRead(16'($urandom), 24'($urandom), cfg, (n % 5) == 4, 1'b0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule